// File: doc/BRIEF.md
# Colour Matrix Coefficient Loader

This block takes a set of nine colour-transform coefficients, one 64-bit word per accepted cycle. Each word is in signed-magnitude fixed point, with 32 fractional bits and the sign in the top bit. The block turns each word into a 15-bit two's-complement value with 12 fractional bits and 3 integer bits, including sign. Fractional bits below the output precision are dropped, not rounded. Magnitude bits above the output range are masked away and are never tested.

Converted values first go to a staging area. One cycle after the ninth word, the block raises a single-cycle completion pulse together with a pass flag or a fail flag. The nine values replace the committed coefficient bank only when every word of the set passed the range test. A failed set leaves the bank as it was.

A start pulse throws away a partly collected set, so the upstream producer can resynchronise at any time.

Top module: `ctm_coef_loader`

## Requirements
- R1: Only input bits 34:20 form the 15-bit magnitude field. Bits 19:0 are truncated and bits 62:35 have no effect on the result or on the range test.
- R2: With bit 63 clear, the converted value equals the magnitude field, and the word is rejected when bit 14 of the field is set.
- R3: With bit 63 set, the converted value is the 15-bit two's complement of the field, and the word is rejected when bit 14 of that result is clear. So field 0x2000 gives 0x6000 and field 0x4000 gives 0x4000, and both pass. Field 0 and fields above 0x4000 fail.
- R4: A set is exactly nine accepted words. `done_o` is high for exactly the one cycle after the edge that accepts the ninth word, and never earlier.
- R5: While `done_o` is high, exactly one of `ok_o` and `err_o` is high. `ok_o` is high when all nine words passed. Both flags are low whenever `done_o` is low.
- R6: On a passing set, `coef_o` takes the nine converted values at the same edge that raises `done_o`. Coefficient k, counted in arrival order from 0, sits in `coef_o[15k+14:15k]`.
- R7: A set with any rejected word leaves `coef_o` unchanged.
- R8: `start_i` discards the partial set and clears its failure history, so the next accepted word is coefficient 0. A word presented in the same cycle as `start_i` is ignored.
- R9: After reset, `coef_o` is all zero, `done_o`, `ok_o` and `err_o` are low, and the next word is coefficient 0.
- R10: Idle cycles with `coef_valid_i` low between words of a set do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Discard partial set and restart at coefficient 0 |
| coef_valid_i | input | 1 | `coef_i` carries a coefficient this cycle |
| coef_i | input | 64 | Signed-magnitude coefficient, sign in bit 63 |
| done_o | output | 1 | One-cycle pulse after the ninth word |
| ok_o | output | 1 | Set passed and was committed (valid with `done_o`) |
| err_o | output | 1 | Set failed and was dropped (valid with `done_o`) |
| coef_o | output | 135 | Committed bank, nine 15-bit two's-complement values |

## Verification
The bench drives negative words with field 0x2000 and 0x4000. A design that tests the range before negating would reject these legal most-negative values. It also drives negative zero and fields just past 0x4000, which a design that tests only the raw field would wrongly accept. Garbage in bits 62:35 and 19:0 exposes a wrong extraction window. A bad word in the last slot, on a word that coincides with a start pulse, and inside a discarded partial set targets a failure flag that is sampled too early or never cleared, and a bank that is updated before the whole set is known.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int CTM_N_COEF = 9;
  localparam int CTM_IN_W   = 64;
  localparam int CTM_OUT_W  = 15;
  localparam int CTM_DROP_W = 20;
endpackage

// File: rtl/ctm_conv.sv
// Signed-magnitude to two's-complement conversion with post-negation range test.
module ctm_conv #(
  parameter int IN_W   = 64,
  parameter int OUT_W  = 15,
  parameter int DROP_W = 20
) (
  input  logic [IN_W-1:0]  coef_i,
  output logic [OUT_W-1:0] val_o,
  output logic             ovf_o
);
  localparam int SIGN_B = IN_W - 1;

  logic             neg;
  logic [OUT_W-1:0] field;

  assign neg   = coef_i[SIGN_B];
  assign field = coef_i[DROP_W+OUT_W-1:DROP_W];

  always_comb begin
    val_o = neg ? -field : field;
    // test after negation so the most negative code still passes
    ovf_o = neg ^ val_o[OUT_W-1];
  end
endmodule

// File: rtl/ctm_collect.sv
// Counts words, stages converted values, tracks failures across a set.
module ctm_collect #(
  parameter int N_COEF = 9,
  parameter int OUT_W  = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic [OUT_W-1:0]        val_i,
  input  logic                    ovf_i,
  output logic                    commit_o,
  output logic [N_COEF*OUT_W-1:0] set_o,
  output logic                    done_o,
  output logic                    ok_o,
  output logic                    err_o
);
  localparam int IDX_W = $clog2(N_COEF);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_COEF - 1);

  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic             accept, last, bad;
  logic [OUT_W-1:0] stage_q [N_COEF-1];

  assign accept   = valid_i && !start_i;
  assign last     = accept && (idx_q == LAST_IDX);
  assign bad      = err_q || ovf_i;
  assign commit_o = last && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (start_i) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      idx_q <= last ? '0 : idx_q + IDX_W'(1);
      err_q <= last ? 1'b0 : bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= last;
      ok_o   <= last && !bad;
      err_o  <= last && bad;
    end
  end

  // last slot is never staged: it goes straight to the bank with the commit
  for (genvar k = 0; k < N_COEF - 1; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   stage_q[k] <= '0;
      else if (accept && idx_q == IDX_W'(k))         stage_q[k] <= val_i;
    end
    assign set_o[k*OUT_W +: OUT_W] = stage_q[k];
  end
  assign set_o[(N_COEF-1)*OUT_W +: OUT_W] = val_i;
endmodule

// File: rtl/ctm_store.sv
// Committed coefficient bank.
module ctm_store #(
  parameter int N_COEF = 9,
  parameter int OUT_W  = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [N_COEF*OUT_W-1:0] set_i,
  output logic [N_COEF*OUT_W-1:0] coef_o
);
  for (genvar k = 0; k < N_COEF; k++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     coef_o[k*OUT_W +: OUT_W] <= '0;
      else if (load_i) coef_o[k*OUT_W +: OUT_W] <= set_i[k*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/ctm_coef_loader.sv
module ctm_coef_loader
  import ctm_pkg::*;
#(
  parameter int N_COEF = CTM_N_COEF,
  parameter int IN_W   = CTM_IN_W,
  parameter int OUT_W  = CTM_OUT_W,
  parameter int DROP_W = CTM_DROP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    coef_valid_i,
  input  logic [IN_W-1:0]         coef_i,
  output logic                    done_o,
  output logic                    ok_o,
  output logic                    err_o,
  output logic [N_COEF*OUT_W-1:0] coef_o
);
  logic [OUT_W-1:0]        word_val;
  logic                    word_ovf;
  logic                    commit;
  logic [N_COEF*OUT_W-1:0] set_flat;

  ctm_conv #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP_W(DROP_W)) conv_i (
    .coef_i (coef_i),
    .val_o  (word_val),
    .ovf_o  (word_ovf)
  );

  ctm_collect #(.N_COEF(N_COEF), .OUT_W(OUT_W)) collect_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .valid_i  (coef_valid_i),
    .val_i    (word_val),
    .ovf_i    (word_ovf),
    .commit_o (commit),
    .set_o    (set_flat),
    .done_o   (done_o),
    .ok_o     (ok_o),
    .err_o    (err_o)
  );

  ctm_store #(.N_COEF(N_COEF), .OUT_W(OUT_W)) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .set_i  (set_flat),
    .coef_o (coef_o)
  );
endmodule

// File: rtl/ctm_coef_loader_chk.sv
module ctm_coef_loader_chk #(
  parameter int N_COEF = 9,
  parameter int IN_W   = 64,
  parameter int OUT_W  = 15,
  parameter int DROP_W = 20
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    coef_valid_i,
  input logic [IN_W-1:0]         coef_i,
  input logic                    done_o,
  input logic                    ok_o,
  input logic                    err_o,
  input logic [N_COEF*OUT_W-1:0] coef_o,
  input logic                    word_ovf_i
);
  localparam logic [OUT_W-1:0] EDGE_FIELD = OUT_W'(1) << (OUT_W - 2);

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(coef_valid_i && !start_i));

  p_flag_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o ^ err_o));

  p_flags_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(ok_o || err_o));

  p_bank_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && ok_o) |-> $stable(coef_o));

  p_pos_ovf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_valid_i && !coef_i[IN_W-1] && coef_i[DROP_W+OUT_W-1]) |-> word_ovf_i);

  p_neg_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_valid_i && coef_i[IN_W-1] && coef_i[DROP_W+OUT_W-1:DROP_W] == EDGE_FIELD)
      |-> !word_ovf_i);
endmodule

bind ctm_coef_loader ctm_coef_loader_chk #(
  .N_COEF(N_COEF), .IN_W(IN_W), .OUT_W(OUT_W), .DROP_W(DROP_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .coef_valid_i (coef_valid_i),
  .coef_i       (coef_i),
  .done_o       (done_o),
  .ok_o         (ok_o),
  .err_o        (err_o),
  .coef_o       (coef_o),
  .word_ovf_i   (word_ovf)
);

// File: tb/ctm_coef_loader_tb_top.sv
`timescale 1ns/1ps
module ctm_coef_loader_tb_top;
  localparam int N   = 9;
  localparam int W   = 15;
  localparam int TOT = N * W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           cvalid = 1'b0;
  logic [63:0]    coef = '0;
  logic           done, ok, err;
  logic [TOT-1:0] bank;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q [N];

  always #2 clk = ~clk;

  ctm_coef_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .coef_valid_i(cvalid),
    .coef_i(coef), .done_o(done), .ok_o(ok), .err_o(err), .coef_o(bank)
  );

  task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit neg, input logic [14:0] field,
                                     input logic [27:0] hi, input logic [19:0] lo);
    return {neg, hi, field, lo};
  endfunction

  // expected {reject, value} from R1..R3
  function automatic logic [15:0] model(input logic [63:0] w);
    logic [14:0] f;
    logic [14:0] v;
    bit rej;
    f = w[34:20];
    if (w[63]) begin
      v = 15'(~f + 15'd1);
      rej = (v[14] == 1'b0);
    end else begin
      v = f;
      rej = f[14];
    end
    return {rej, v};
  endfunction

  function automatic logic [TOT-1:0] exp_flat();
    logic [TOT-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = exp_q[k];
    return r;
  endfunction

  function automatic logic [63:0] rnd_word(input bit want_ok);
    bit neg;
    logic [14:0] f;
    neg = bit'($urandom_range(1, 0));
    if (want_ok) f = neg ? 15'($urandom_range(32'h4000, 1)) : 15'($urandom_range(32'h3FFF, 0));
    else if (neg) f = ($urandom_range(3, 0) == 0) ? 15'd0 : 15'($urandom_range(32'h7FFF, 32'h4001));
    else f = 15'($urandom_range(32'h7FFF, 32'h4000));
    return mk(neg, f, 28'($urandom), 20'($urandom));
  endfunction

  task automatic run_set(input logic [63:0] ws [N], input int max_gap);
    logic [15:0] r;
    logic [W-1:0] nv [N];
    bit bad = 0;
    bit early = 0;
    for (int i = 0; i < N; i++) begin
      r = model(ws[i]);
      nv[i] = r[14:0];
      bad |= r[15];
    end
    for (int i = 0; i < N; i++) begin
      repeat ($urandom_range(max_gap, 0)) @(negedge clk);   // R10 idle gaps
      cvalid = 1'b1;
      coef = ws[i];
      @(negedge clk);
      cvalid = 1'b0;
      if (i < N - 1 && done) early = 1;
    end
    chk("R4 no early done", TOT'(early), TOT'(0));
    chk("R4 done after ninth", TOT'(done), TOT'(1));
    chk("R5 ok flag", TOT'(ok), TOT'(!bad));
    chk("R5 err flag", TOT'(err), TOT'(bad));
    if (!bad) for (int k = 0; k < N; k++) exp_q[k] = nv[k];
    chk(bad ? "R7 bank held" : "R6 bank loaded", bank, exp_flat());
    @(negedge clk);
    chk("R4 done one cycle", TOT'(done), TOT'(0));
    chk("R5 flags low", TOT'({ok, err}), TOT'(0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [63:0] d1 [N];
    logic [63:0] ws [N];
    int seed;
    seed = int'($urandom(32'h1F2E3D));
    for (int k = 0; k < N; k++) exp_q[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 bank zero", bank, '0);
    chk("R9 flags low", TOT'({done, ok, err}), TOT'(0));

    d1[0] = mk(0, 15'h1000, 28'h0, 20'h0);
    d1[1] = mk(1, 15'h2000, 28'h0, 20'h0);
    d1[2] = mk(1, 15'h4000, 28'h0, 20'h0);
    d1[3] = mk(0, 15'h3FFF, 28'h0, 20'h0);
    d1[4] = mk(0, 15'h0ABC, 28'hFFFFFFF, 20'hFFFFF);
    d1[5] = mk(0, 15'h0000, 28'h0, 20'h0);
    d1[6] = mk(1, 15'h0001, 28'h0, 20'h0);
    d1[7] = mk(0, 15'h0123, 28'h5A5A5A5, 20'h12345);
    d1[8] = mk(1, 15'h0FFF, 28'h8000001, 20'h0);
    run_set(d1, 0);
    chk("R3 neg 0x2000 slot", TOT'(bank[1*W +: W]), TOT'(15'h6000));
    chk("R3 neg 0x4000 slot", TOT'(bank[2*W +: W]), TOT'(15'h4000));
    chk("R1 high and low bits ignored", TOT'(bank[4*W +: W]), TOT'(15'h0ABC));
    chk("R3 neg one", TOT'(bank[6*W +: W]), TOT'(15'h7FFF));
    chk("R2 positive max", TOT'(bank[3*W +: W]), TOT'(15'h3FFF));

    ws = d1; ws[3] = mk(0, 15'h4000, 28'h0, 20'h0);   // R2 reject
    run_set(ws, 1);
    ws = d1; ws[8] = mk(1, 15'h0000, 28'h0, 20'h0);   // R3 negative zero reject
    run_set(ws, 0);
    ws = d1; ws[0] = mk(1, 15'h4001, 28'h0, 20'h0);   // R3 past the edge
    run_set(ws, 2);

    // R8 partial set with a bad word, then restart
    for (int i = 0; i < 5; i++) begin
      cvalid = 1'b1;
      coef = (i == 2) ? mk(0, 15'h7000, 28'h0, 20'h0) : d1[i];
      @(negedge clk);
    end
    cvalid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 no done after start", TOT'(done), TOT'(0));
    for (int k = 0; k < N; k++) ws[k] = mk(0, 15'(k * 32'h111), 28'h0, 20'h0);
    run_set(ws, 0);
    chk("R8 slot0 after restart", TOT'(bank[0 +: W]), TOT'(15'h0000));

    // R8 word coinciding with start is dropped
    start = 1'b1;
    cvalid = 1'b1;
    coef = mk(0, 15'h7777, 28'h0, 20'h0);
    @(negedge clk);
    start = 1'b0;
    cvalid = 1'b0;
    for (int k = 0; k < N; k++) ws[k] = mk(1, 15'(k + 32'h10), 28'h0, 20'h0);
    run_set(ws, 0);
    chk("R8 start word ignored", TOT'(bank[0 +: W]), TOT'(15'(-15'h10)));

    for (int s = 0; s < 40; s++) begin
      int bad_at;
      bad_at = ($urandom_range(2, 0) == 0) ? int'($urandom_range(N - 1, 0)) : -1;
      for (int k = 0; k < N; k++) ws[k] = rnd_word(k != bad_at);
      run_set(ws, 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule